// File: doc/BRIEF.md
# Burst Transmitter Power Control Loop

This block closes the digital half of an automatic optical power loop for a burst-mode laser transmitter. It watches the serial transmit bit stream on the bit-rate clock and counts runs of identical bits. When a run of zeros or a run of ones reaches a programmable length, the optical level for that polarity has settled. The block then samples the matching level comparator: a run of zeros samples the low-level comparator and a run of ones samples the high-level comparator.

Each sample steps one 8-bit current code by one LSB. A low-level sample adjusts the bias code and a high-level sample adjusts the modulation code. The code moves down when the comparator reports the level above its reference and up otherwise, and it saturates at both ends. A one-cycle strobe marks each update.

A hold input freezes both loops while the burst is off. The analog mirror, the photodiode and the comparators sit outside the block.

Top module: `burst_power_ctrl`

## Requirements
- R1: While `rst_n` is low, `biasCode` equals `BIAS_INIT`, `modCode` equals `MOD_INIT`, both strobes are 0, and the run count is cleared.
- R2: The run length is the number of consecutive equal `txBit` values sampled on rising edges. The first bit after reset or hold counts as 1, and any bit that differs from the previous one restarts the count at 1.
- R3: On the edge where a run reaches `runLen`, exactly one update takes effect. A run of 0s (`txBit`=0) updates the bias code from `zeroAbove`, and a run of 1s (`txBit`=1) updates the modulation code from `oneAbove`.
- R4: The run count saturates at `runLen`, so a run of any length longer than `runLen` produces only one update. A further update needs a change of bit.
- R5: A comparator value of 1 (level above reference) decrements the selected code by 1. A value of 0 increments it by 1.
- R6: A code at 0 that is told to decrement stays at 0. A code at 255 that is told to increment stays at 255.
- R7: `biasStrobe` or `modStrobe` is high for the single cycle after the edge that updated that code, and both are never high together. A code never changes without its strobe.
- R8: While `holdEn` is 1, no code changes and no strobe is raised, and the run count is cleared.
- R9: A `runLen` of 0 disables all updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txBit | input | 1 | Transmit data bit for this clock |
| holdEn | input | 1 | Freeze loops (burst disabled) |
| runLen | input | RUN_W | Run length that qualifies a sample; 0 disables |
| zeroAbove | input | 1 | Low-level comparator: 1 = level above reference |
| oneAbove | input | 1 | High-level comparator: 1 = level above reference |
| biasCode | output | CODE_W | Bias current code |
| modCode | output | CODE_W | Modulation current code |
| biasStrobe | output | 1 | Bias code was updated on the previous edge |
| modStrobe | output | 1 | Modulation code was updated on the previous edge |

## Verification
The assertions assume that `runLen` only changes while `holdEn` is high. They also assume that the comparator bits are valid on every edge where a run may qualify. The bench respects both assumptions. It changes the threshold only inside hold cycles, and it drives the comparators on every cycle from a seeded random source. Its random bit stream flips with low probability, so that runs of the chosen length occur often. Directed stretches force saturation at both code limits, very long runs, a zero threshold and holds in the middle of a run.

// File: rtl/burst_pc_pkg.sv
package burst_pc_pkg;
  // Strobes from run control to the code datapath
  typedef struct packed {
    logic stepBias;  // a qualifying run of 0s: sample low-level comparator
    logic stepMod;   // a qualifying run of 1s: sample high-level comparator
  } sample_t;
endpackage

// File: rtl/burst_run_ctrl.sv
module burst_run_ctrl
  import burst_pc_pkg::*;
#(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txBit,
  input  logic             holdEn,
  input  logic [RUN_W-1:0] runLen,
  output sample_t          sampleReq
);
  logic             prevBit;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] nextCnt;
  logic             advanced;
  logic             qualify;

  always_comb begin
    nextCnt  = runCnt;
    advanced = 1'b0;
    if (runCnt == '0 || txBit != prevBit) begin
      nextCnt  = RUN_W'(1);
      advanced = 1'b1;
    end else if (runCnt < runLen) begin
      nextCnt  = runCnt + RUN_W'(1);
      advanced = 1'b1;
    end
  end

  assign qualify = !holdEn && advanced && (nextCnt == runLen);

  always_comb begin
    sampleReq.stepBias = qualify && !txBit;
    sampleReq.stepMod  = qualify && txBit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCnt  <= '0;
      prevBit <= 1'b0;
    end else if (holdEn) begin
      runCnt  <= '0;
    end else begin
      runCnt  <= nextCnt;
      prevBit <= txBit;
    end
  end
endmodule

// File: rtl/burst_code_path.sv
module burst_code_path
  import burst_pc_pkg::*;
#(
  parameter int          CODE_W    = 8,
  parameter logic [CODE_W-1:0] BIAS_INIT = 8'd128,
  parameter logic [CODE_W-1:0] MOD_INIT  = 8'd96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sample_t           sampleReq,
  input  logic              zeroAbove,
  input  logic              oneAbove,
  output logic [CODE_W-1:0] biasCode,
  output logic [CODE_W-1:0] modCode,
  output logic              biasStrobe,
  output logic              modStrobe
);
  localparam int                NLOOP    = 2;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] codeQ  [NLOOP];
  logic              stepIn [NLOOP];
  logic              above  [NLOOP];
  logic              strobeQ[NLOOP];

  assign stepIn[0] = sampleReq.stepBias;
  assign stepIn[1] = sampleReq.stepMod;
  assign above[0]  = zeroAbove;
  assign above[1]  = oneAbove;

  for (genvar g = 0; g < NLOOP; g++) begin : g_loop
    localparam logic [CODE_W-1:0] INIT = (g == 0) ? BIAS_INIT : MOD_INIT;
    logic [CODE_W-1:0] stepped;

    always_comb begin
      if (above[g])
        stepped = (codeQ[g] == '0) ? codeQ[g] : codeQ[g] - CODE_W'(1);
      else
        stepped = (codeQ[g] == CODE_MAX) ? codeQ[g] : codeQ[g] + CODE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codeQ[g]   <= INIT;
        strobeQ[g] <= 1'b0;
      end else begin
        strobeQ[g] <= stepIn[g];
        if (stepIn[g]) codeQ[g] <= stepped;
      end
    end
  end

  assign biasCode   = codeQ[0];
  assign modCode    = codeQ[1];
  assign biasStrobe = strobeQ[0];
  assign modStrobe  = strobeQ[1];
endmodule

// File: rtl/burst_power_ctrl.sv
module burst_power_ctrl
  import burst_pc_pkg::*;
#(
  parameter int                CODE_W    = 8,
  parameter int                RUN_W     = 8,
  parameter logic [CODE_W-1:0] BIAS_INIT = 8'd128,
  parameter logic [CODE_W-1:0] MOD_INIT  = 8'd96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txBit,
  input  logic              holdEn,
  input  logic [RUN_W-1:0]  runLen,
  input  logic              zeroAbove,
  input  logic              oneAbove,
  output logic [CODE_W-1:0] biasCode,
  output logic [CODE_W-1:0] modCode,
  output logic              biasStrobe,
  output logic              modStrobe
);
  sample_t sampleReq;

  burst_run_ctrl #(.RUN_W(RUN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .txBit(txBit), .holdEn(holdEn),
    .runLen(runLen), .sampleReq(sampleReq)
  );

  burst_code_path #(.CODE_W(CODE_W), .BIAS_INIT(BIAS_INIT), .MOD_INIT(MOD_INIT)) path_i (
    .clk(clk), .rst_n(rst_n), .sampleReq(sampleReq),
    .zeroAbove(zeroAbove), .oneAbove(oneAbove),
    .biasCode(biasCode), .modCode(modCode),
    .biasStrobe(biasStrobe), .modStrobe(modStrobe)
  );
endmodule

// File: rtl/burst_power_ctrl_chk.sv
module burst_power_ctrl_chk #(
  parameter int CODE_W = 8,
  parameter int RUN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              holdEn,
  input logic [RUN_W-1:0]  runLen,
  input logic              zeroAbove,
  input logic              oneAbove,
  input logic [CODE_W-1:0] biasCode,
  input logic [CODE_W-1:0] modCode,
  input logic              biasStrobe,
  input logic              modStrobe
);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({biasStrobe, modStrobe}));

  // R7
  bias_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !biasStrobe |-> $stable(biasCode));

  // R7
  mod_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !modStrobe |-> $stable(modCode));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdEn |=> (!biasStrobe && !modStrobe && $stable(biasCode) && $stable(modCode)));

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runLen == '0) |=> (!biasStrobe && !modStrobe));

  // R5
  bias_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (biasStrobe && $past(zeroAbove) && $past(biasCode) != '0)
      |-> (biasCode == $past(biasCode) - CODE_W'(1)));

  // R5
  mod_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modStrobe && !$past(oneAbove) && $past(modCode) != {CODE_W{1'b1}})
      |-> (modCode == $past(modCode) + CODE_W'(1)));
endmodule

bind burst_power_ctrl burst_power_ctrl_chk #(.CODE_W(CODE_W), .RUN_W(RUN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .holdEn(holdEn), .runLen(runLen),
  .zeroAbove(zeroAbove), .oneAbove(oneAbove),
  .biasCode(biasCode), .modCode(modCode),
  .biasStrobe(biasStrobe), .modStrobe(modStrobe)
);

// File: tb/burst_power_ctrl_tb.sv
module burst_power_ctrl_tb_top;
  localparam int BIAS0 = 128;
  localparam int MOD0  = 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txBit = 1'b0;
  logic       holdEn = 1'b0;
  logic [7:0] runLen = 8'd5;
  logic       zeroAbove = 1'b0;
  logic       oneAbove = 1'b0;
  logic [7:0] biasCode, modCode;
  logic       biasStrobe, modStrobe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  // bench reference state
  int  mCnt = 0;
  logic mPrev = 1'b0;
  int  mBias = BIAS0;
  int  mMod  = MOD0;
  logic eBs = 1'b0;
  logic eMs = 1'b0;

  always #10 clk = ~clk;

  burst_power_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .txBit(txBit), .holdEn(holdEn), .runLen(runLen),
    .zeroAbove(zeroAbove), .oneAbove(oneAbove),
    .biasCode(biasCode), .modCode(modCode),
    .biasStrobe(biasStrobe), .modStrobe(modStrobe)
  );

  function automatic int stepCode(int code, logic above);
    if (above) return (code == 0) ? 0 : code - 1;
    return (code == 255) ? 255 : code + 1;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    check("biasCode", biasCode, mBias);
    check("modCode", modCode, mMod);
    check("biasStrobe (R7)", biasStrobe, eBs);
    check("modStrobe (R7)", modStrobe, eMs);
  endtask

  // called at a falling edge: drive, advance one rising edge, check at next falling edge
  task automatic cyc(logic b, logic h, logic za, logic oa);
    int  nCnt;
    logic grew;
    txBit = b; holdEn = h; zeroAbove = za; oneAbove = oa;
    eBs = 1'b0; eMs = 1'b0;
    if (h) begin
      mCnt = 0;
    end else begin
      grew = 1'b1;
      if (mCnt == 0 || b != mPrev) nCnt = 1;
      else if (mCnt < int'(runLen)) nCnt = mCnt + 1;
      else begin nCnt = mCnt; grew = 1'b0; end
      if (grew && nCnt == int'(runLen)) begin
        if (b) begin eMs = 1'b1; mMod = stepCode(mMod, oa); end
        else   begin eBs = 1'b1; mBias = stepCode(mBias, za); end
      end
      mCnt = nCnt; mPrev = b;
    end
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  task automatic setLen(int n);
    runLen = 8'(n);
    cyc(txBit, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired: actual=%0d expected=<100000 cycles", cycles);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = $urandom(32'h5eed_1234);
    // R1 reset values
    tag = "R1";
    repeat (3) @(negedge clk);
    checkAll();
    rst_n = 1'b1;
    @(negedge clk);
    checkAll();

    // R2: count restarts on change; 0,0,1,1,1 with length 3 -> one mod update only
    tag = "R2";
    setLen(3);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    check("modCode after 1-run", modCode, MOD0 + 1);

    // R3: run of 0s updates bias, run of 1s updates mod
    tag = "R3";
    cyc(0, 0, 1, 1); cyc(0, 0, 1, 1); cyc(0, 0, 1, 1);
    check("biasStrobe on 0-run", biasStrobe, 1);
    check("modStrobe on 0-run", modStrobe, 0);

    // R4: long run only one sample
    tag = "R4";
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, 1);
    check("bias after long run", biasCode, BIAS0 - 1);

    // R5: direction from comparator
    tag = "R5";
    cyc(1, 0, 1, 1); cyc(1, 0, 1, 1); cyc(1, 0, 1, 1);
    check("mod decremented", modCode, MOD0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    check("bias incremented", biasCode, BIAS0);

    // R6: saturation with length 1 and alternating bits
    tag = "R6";
    setLen(1);
    for (int i = 0; i < 400; i++) cyc(logic'(i % 2), 0, 1, 0);
    check("bias floor", biasCode, 0);
    check("mod ceiling", modCode, 255);
    for (int i = 0; i < 600; i++) cyc(logic'(i % 2), 0, 0, 1);
    check("bias ceiling", biasCode, 255);
    check("mod floor", modCode, 0);

    // R8: hold mid-run freezes and restarts count
    tag = "R8";
    setLen(4);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    check("no update before 4 after hold", modStrobe, 0);
    cyc(1, 0, 0, 0);
    check("update at 4th bit after hold", modStrobe, 1);

    // R9: zero length disables
    tag = "R9";
    setLen(0);
    for (int i = 0; i < 50; i++) cyc(logic'($urandom_range(0, 1)), 0, 1, 1);
    check("bias unchanged", biasCode, 255);

    // random mix
    tag = "R3";
    for (int blk = 0; blk < 40; blk++) begin
      setLen($urandom_range(1, 6));
      for (int i = 0; i < 200; i++) begin
        logic b;
        b = ($urandom_range(0, 3) == 0) ? ~txBit : txBit;
        cyc(b, logic'($urandom_range(0, 15) == 0),
            logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)));
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule